// File: doc/BRIEF.md
# Multi-Format Serial Audio Transmitter

This block turns stereo parallel samples into a three-wire serial audio stream: a bit clock, a frame clock and one data line. The framing is right-justified, left-justified or I2S-style. The output word length is 16, 18, 20 or 24 bits, and it is chosen separately from the framing. Both selects are static: they are sampled only while reset is held.

In master mode the block makes its own bit clock. Each pulse of a system-clock enable flips the bit clock, and a frame always has exactly 64 bit-clock periods. The block also drives the matching frame clock. In slave mode it follows an external bit clock and frame clock after a two-stage synchronizer. It measures the length of each half-frame so that right-justified words can be placed against the end of the next half.

Samples arrive through a valid/ready handshake. The ready pulse comes once per frame, at the start of the left half. If no sample is offered at that moment, the frame carries zeros.

Top module: `serial_audio_tx`

## Requirements
- R1: While `rst_n` is low, `sdata`, `smp_ready` and `sclk_out` are low.
- R2: In master mode a frame has 64 bit-clock periods, and `lrck_out` changes level every 32 falling bit-clock edges. The left half has `lrck_out` high for framing codes 0, 1 and 2, and low for code 3.
- R3: `sdata` changes only together with a falling edge of the bit clock. The word is sent MSB first in two's complement.
- R4: With framing code 2 (left-justified), the MSB occupies bit slot 0 of each half-frame. Slots are numbered from 0 at the first rising bit-clock edge after the frame clock changes.
- R5: With framing code 3 (I2S-style), the MSB occupies bit slot 1 of each half-frame.
- R6: With framing code 0 (right-justified), the LSB occupies the last slot of each half-frame. The half-frame length is 32 in master mode. In slave mode it is the length measured over the previous half-frame.
- R7: Word-length codes 0, 1, 2 and 3 select 16, 18, 20 and 24 bits. A shorter word is the 24-bit sample rounded half-up to that length. A positive sample that would overflow saturates to the largest positive word. Slots outside the word are low.
- R8: Framing code 1 is reserved and holds `sdata` low.
- R9: `smp_ready` is a single-cycle pulse at the start of each left half-frame. A sample pair is taken only when `smp_valid` is high in that cycle; otherwise the frame sends zeros in both halves.
- R10: In slave mode the block shifts on the external `sclk_in` and `lrck_in`, and it holds `sclk_out` and `lrck_out` low.
- R11: In master mode each cycle with `bit_tick` high toggles `sclk_out`. Without `bit_tick`, `sclk_out` holds its level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset; selects are sampled while it is low |
| master | input | 1 | 1: generate the serial clocks, 0: follow the external clocks |
| fmt_sel | input | 2 | Framing: 0 right-justified, 1 reserved, 2 left-justified, 3 I2S-style |
| len_sel | input | 2 | Word length: 0 16 bits, 1 18, 2 20, 3 24 |
| bit_tick | input | 1 | Half bit-clock enable in master mode |
| sclk_in | input | 1 | External bit clock (slave mode) |
| lrck_in | input | 1 | External frame clock (slave mode) |
| smp_valid | input | 1 | A sample pair is offered |
| smp_left | input | SW | Left sample, two's complement |
| smp_right | input | SW | Right sample, two's complement |
| smp_ready | output | 1 | Sample pair taken this cycle |
| sclk_out | output | 1 | Generated bit clock |
| lrck_out | output | 1 | Generated frame clock |
| sdata | output | 1 | Serial data |

## Verification
A wrong slot counter or start offset misplaces the whole word within one half-frame. That shows at once as a shifted bit pattern on `sdata`. A wrong half-frame measurement only affects right-justified words, and only from the second frame onward, so slave checks skip the first frame. Rounding or saturation faults show as a wrong LSB group in the first captured word. A ready pulse in the wrong cycle shows as a lost or zero-filled frame on the very next frame.

// File: rtl/serial_audio_tx.sv
module serial_audio_tx #(
  parameter int SW     = 24,
  parameter int SLOT_W = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          master,
  input  logic [1:0]    fmt_sel,
  input  logic [1:0]    len_sel,
  input  logic          bit_tick,
  input  logic          sclk_in,
  input  logic          lrck_in,
  input  logic          smp_valid,
  input  logic [SW-1:0] smp_left,
  input  logic [SW-1:0] smp_right,
  output logic          smp_ready,
  output logic          sclk_out,
  output logic          lrck_out,
  output logic          sdata
);

  localparam int IDXW = $clog2(SW);
  localparam logic [SLOT_W-1:0] SLOT_MAX = '1;
  localparam logic [SLOT_W-1:0] HALF_DEF = SLOT_W'(32);
  localparam logic [1:0] FMT_RJ = 2'd0, FMT_RSV = 2'd1, FMT_I2S = 2'd3;

  function automatic int word_len(input logic [1:0] c);
    return (c == 2'd3) ? 24 : 16 + 2 * int'(c);
  endfunction

  function automatic logic [SW-1:0] round_word(input logic [SW-1:0] x, input int w);
    int sh;
    logic [SW:0] s;
    logic [SW-1:0] mask;
    sh = SW - w;
    if (sh <= 0) return x;
    s = {x[SW-1], x} + ((SW+1)'(1) << (sh - 1));
    mask = {SW{1'b1}} << sh;
    if (!x[SW-1] && s[SW-1]) return {1'b0, {(SW-1){1'b1}}} & mask;
    return s[SW-1:0] & mask;
  endfunction

  logic       bclk_g;
  logic [5:0] mcnt;
  logic [5:0] mcnt_nx;
  logic       s1b, s2b, bd, s1l, s2l;
  logic       is_i2s, fe, left_fe, boundary;
  logic       left_q, synced;
  logic [SLOT_W-1:0] slot, halflen;
  logic [SW-1:0] wl, wr, cur;
  int         w, st, idx;
  logic       bit_ok;
  logic [IDXW-1:0] pos;

  assign is_i2s  = (fmt_sel == FMT_I2S);
  assign mcnt_nx = mcnt + 6'd1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bclk_g <= 1'b0;
      mcnt   <= '1;
    end else if (master && bit_tick) begin
      bclk_g <= ~bclk_g;
      if (bclk_g) mcnt <= mcnt_nx;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1b <= 1'b0; s2b <= 1'b0; bd <= 1'b0;
      s1l <= 1'b0; s2l <= 1'b0;
    end else begin
      s1b <= sclk_in; s2b <= s1b; bd <= s2b;
      s1l <= lrck_in; s2l <= s1l;
    end

  assign fe       = master ? (bit_tick & bclk_g) : (bd & ~s2b);
  assign left_fe  = master ? ~mcnt_nx[5] : (is_i2s ? ~s2l : s2l);
  assign boundary = fe && (left_fe != left_q);
  assign smp_ready = rst_n & boundary & left_fe;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      left_q  <= 1'b0;
      slot    <= '0;
      halflen <= HALF_DEF;
      synced  <= 1'b0;
      wl      <= '0;
      wr      <= '0;
    end else if (fe) begin
      left_q <= left_fe;
      if (boundary) begin
        slot   <= '0;
        synced <= 1'b1;
        if (synced) halflen <= (slot == SLOT_MAX) ? SLOT_MAX : slot + 1'b1;
        if (left_fe) begin
          wl <= smp_valid ? round_word(smp_left, word_len(len_sel)) : '0;
          wr <= smp_valid ? round_word(smp_right, word_len(len_sel)) : '0;
        end
      end else if (slot != SLOT_MAX) begin
        slot <= slot + 1'b1;
      end
    end

  always_comb begin
    w = word_len(len_sel);
    case (fmt_sel)
      FMT_RJ:  st = int'(halflen) - w;
      FMT_I2S: st = 1;
      default: st = 0;
    endcase
    idx    = int'(slot) - st;
    cur    = left_q ? wl : wr;
    bit_ok = synced && (fmt_sel != FMT_RSV) && (idx >= 0) && (idx < w);
    pos    = bit_ok ? IDXW'(SW - 1 - idx) : '0;
    sdata  = rst_n && bit_ok && cur[pos];
  end

  assign sclk_out = master & bclk_g;
  assign lrck_out = master & (is_i2s ? mcnt[5] : ~mcnt[5]);

endmodule

module serial_audio_tx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       master,
  input logic [1:0] fmt_sel,
  input logic       smp_ready,
  input logic       sclk_out,
  input logic       lrck_out,
  input logic       sdata
);
  logic       lr_p, sc_p, sd_p, armed;
  logic [6:0] falls;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      lr_p <= 1'b0; sc_p <= 1'b0; sd_p <= 1'b0; armed <= 1'b0; falls <= '0;
    end else begin
      if (lrck_out != lr_p) begin
        falls <= '0;
        armed <= sc_p && !sclk_out;
      end else if (sc_p && !sclk_out) begin
        falls <= falls + 7'd1;
      end
      lr_p <= lrck_out;
      sc_p <= sclk_out;
      sd_p <= sdata;
    end

  always @(posedge clk)
    if (!rst_n) AST_RST_QUIET: assert (!sdata && !smp_ready && !sclk_out); // R1

  AST_HALF_32: assert property (@(posedge clk) disable iff (!rst_n)
    (master && armed && (lrck_out != lr_p)) |-> (falls == 7'd31)); // R2
  AST_DATA_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (master && (sdata != sd_p)) |-> (sc_p && !sclk_out)); // R3
  AST_RSVD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt_sel == 2'd1) |-> !sdata); // R8
  AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    smp_ready |=> !smp_ready); // R9
  AST_SLAVE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !master |-> (!sclk_out && !lrck_out)); // R10
endmodule

bind serial_audio_tx serial_audio_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .master(master), .fmt_sel(fmt_sel),
  .smp_ready(smp_ready), .sclk_out(sclk_out), .lrck_out(lrck_out), .sdata(sdata)
);

// File: tb/sim_serial_audio_tx.sv
module sim_serial_audio_tx;
  localparam int CLK_P = 10;
  localparam int NV = 6;
  // fmt[99:98] len[97:96] L[95:72] R[71:48] expL[47:24] expR[23:0]
  localparam logic [99:0] VEC [NV] = '{
    {2'd2, 2'd3, 24'h123456, 24'hABCDEF, 24'h123456, 24'hABCDEF},
    {2'd3, 2'd0, 24'h123480, 24'hFEDC7F, 24'h123500, 24'hFEDC00},
    {2'd0, 2'd1, 24'h7FFFFF, 24'h800000, 24'h7FFFC0, 24'h800000},
    {2'd0, 2'd2, 24'h000018, 24'h000017, 24'h000020, 24'h000010},
    {2'd1, 2'd3, 24'hFFFFFF, 24'hFFFFFF, 24'h000000, 24'h000000},
    {2'd2, 2'd0, 24'hFFFF80, 24'h00FF00, 24'h000000, 24'h00FF00}
  };

  logic clk = 0, rst_n = 0, master = 1, bit_tick = 0, sclk_in = 1, lrck_in = 0, smp_valid = 0;
  logic [1:0] fmt = 2, len = 3;
  logic [23:0] smp_left = 0, smp_right = 0;
  logic smp_ready, sclk_out, lrck_out, sdata;
  logic tick_en = 0;
  int checks = 0, fails = 0, acc = 0;

  serial_audio_tx u0 (
    .clk(clk), .rst_n(rst_n), .master(master), .fmt_sel(fmt), .len_sel(len),
    .bit_tick(bit_tick), .sclk_in(sclk_in), .lrck_in(lrck_in),
    .smp_valid(smp_valid), .smp_left(smp_left), .smp_right(smp_right),
    .smp_ready(smp_ready), .sclk_out(sclk_out), .lrck_out(lrck_out), .sdata(sdata)
  );

  always #(CLK_P/2) clk = ~clk;

  initial forever begin
    @(posedge clk); #2;
    if (tick_en) bit_tick = ~bit_tick;
  end

  initial forever begin
    @(negedge clk);
    if (rst_n && smp_ready && smp_valid) acc++;
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  function automatic logic exp_bit(input logic [1:0] f, input logic [1:0] l,
                                   input logic [23:0] wv, input int s, input int half);
    int wn, st, ix;
    wn = (l == 3) ? 24 : 16 + 2 * int'(l);
    st = (f == 0) ? half - wn : (f == 3) ? 1 : 0;
    ix = s - st;
    if (f == 1 || ix < 0 || ix >= wn) return 1'b0;
    return wv[23 - ix];
  endfunction

  task automatic do_reset(input logic ms, input logic [1:0] f, input logic [1:0] l);
    @(posedge clk); #2;
    tick_en = 0; bit_tick = 0; rst_n = 0;
    master = ms; fmt = f; len = l;
    sclk_in = 1; lrck_in = (f == 3) ? 1'b1 : 1'b0;
    repeat (3) @(negedge clk);
    chk(!sdata && !smp_ready && !sclk_out, "R1 reset outputs",
        {61'd0, sdata, smp_ready, sclk_out}, 64'd0);
    @(posedge clk); #2;
    rst_n = 1; acc = 0;
  endtask

  task automatic grab_frame(input logic leftlvl, output logic [63:0] bits, output logic [63:0] lrs);
    logic prev_sc, started, last_lr, have_last;
    int n;
    prev_sc = sclk_out; started = 0; have_last = 0; last_lr = 0; n = 0;
    bits = '0; lrs = '0;
    while (n < 64) begin
      @(negedge clk);
      if (!prev_sc && sclk_out) begin
        if (!started && have_last && last_lr != leftlvl && lrck_out == leftlvl) started = 1;
        if (started) begin
          bits[63-n] = sdata;
          lrs[63-n]  = lrck_out;
          n++;
        end
        last_lr = lrck_out; have_last = 1;
      end
      prev_sc = sclk_out;
    end
  endtask

  function automatic logic [63:0] model_frame(input logic [1:0] f, input logic [1:0] l,
                                              input logic [23:0] el, input logic [23:0] er);
    logic [63:0] m;
    for (int s = 0; s < 32; s++) begin
      m[63-s] = exp_bit(f, l, el, s, 32);
      m[31-s] = exp_bit(f, l, er, s, 32);
    end
    return m;
  endfunction

  task automatic run_slave(input logic [1:0] f, input logic [1:0] l, input int h, input int nfr,
                           input logic [23:0] el, input logic [23:0] er, input string tag);
    logic leftlvl;
    int errs;
    leftlvl = (f == 3) ? 1'b0 : 1'b1;
    for (int fr = 0; fr < nfr; fr++) begin
      errs = 0;
      for (int hf = 0; hf < 2; hf++) begin
        for (int s = 0; s < h; s++) begin
          @(posedge clk); #2;
          sclk_in = 0;
          if (s == 0) lrck_in = (hf == 0) ? leftlvl : ~leftlvl;
          repeat (5) @(posedge clk);
          @(negedge clk);
          if (sdata !== exp_bit(f, l, (hf == 0) ? el : er, s, h)) errs++;
          @(posedge clk); #2;
          sclk_in = 1;
          repeat (5) @(posedge clk);
        end
      end
      if (fr >= 1) chk(errs == 0, tag, 64'(errs), 64'd0);
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    fails++;
    $display("FAIL watchdog R1 act=timeout exp=done");
    finish_run();
  end

  initial begin
    logic [63:0] bits, lrs, em, elr;
    logic [1:0] f, l;
    logic leftlvl;
    string tag;

    for (int vi = 0; vi < NV; vi++) begin
      f = VEC[vi][99:98]; l = VEC[vi][97:96];
      do_reset(1'b1, f, l);
      smp_valid = 1; smp_left = VEC[vi][95:72]; smp_right = VEC[vi][71:48];
      tick_en = 1;
      leftlvl = (f == 3) ? 1'b0 : 1'b1;
      grab_frame(leftlvl, bits, lrs);
      em = model_frame(f, l, VEC[vi][47:24], VEC[vi][23:0]);
      case (f)
        2'd0: tag = "R6 R7 right-justified frame";
        2'd1: tag = "R8 reserved framing";
        2'd2: tag = "R4 R7 left-justified frame";
        default: tag = "R5 R7 I2S-style frame";
      endcase
      chk(bits == em, tag, bits, em);
      elr = leftlvl ? {32'hFFFFFFFF, 32'h0} : {32'h0, 32'hFFFFFFFF};
      chk(lrs == elr, "R2 frame clock per slot", lrs, elr);
      chk(acc == 1, "R9 one accept per frame", 64'(acc), 64'd1);
    end

    // R9: no valid at the left boundary sends a zero frame
    do_reset(1'b1, 2'd2, 2'd3);
    smp_valid = 1; smp_left = 24'h654321; smp_right = 24'h13579B;
    tick_en = 1;
    grab_frame(1'b1, bits, lrs);
    chk(bits == {8'h65, 8'h43, 8'h21, 8'h00, 8'h13, 8'h57, 8'h9B, 8'h00}, "R3 R4 MSB-first word",
        bits, {8'h65, 8'h43, 8'h21, 8'h00, 8'h13, 8'h57, 8'h9B, 8'h00});
    @(posedge clk); #2;
    smp_valid = 0;
    grab_frame(1'b1, bits, lrs);
    chk(bits == 64'd0, "R9 zero fill without valid", bits, 64'd0);
    chk(acc == 1, "R9 no accept without valid", 64'(acc), 64'd1);

    // R11: bit clock moves only on bit_tick
    do_reset(1'b1, 2'd2, 2'd3);
    repeat (5) @(negedge clk);
    chk(sclk_out == 0, "R11 idle without tick", 64'(sclk_out), 64'd0);
    @(posedge clk); #2; bit_tick = 1;
    @(posedge clk); #2; bit_tick = 0;
    @(negedge clk);
    chk(sclk_out == 1, "R11 first tick raises", 64'(sclk_out), 64'd1);
    repeat (4) @(negedge clk);
    chk(sclk_out == 1, "R11 level held", 64'(sclk_out), 64'd1);
    @(posedge clk); #2; bit_tick = 1;
    @(posedge clk); #2; bit_tick = 0;
    @(negedge clk);
    chk(sclk_out == 0 && lrck_out == 1, "R2 left half after first fall",
        {62'd0, sclk_out, lrck_out}, 64'd1);

    // R10 / R6: slave, right-justified 16-bit in 24-slot halves
    do_reset(1'b0, 2'd0, 2'd0);
    smp_valid = 1; smp_left = 24'h123456; smp_right = 24'h800000;
    run_slave(2'd0, 2'd0, 24, 3, 24'h123400, 24'h800000, "R6 R10 slave right-justified");
    chk(sclk_out == 0 && lrck_out == 0, "R10 clocks low in slave",
        {62'd0, sclk_out, lrck_out}, 64'd0);

    // R10 / R5: slave, I2S-style 24-bit in 32-slot halves
    do_reset(1'b0, 2'd3, 2'd3);
    smp_valid = 1; smp_left = 24'hA5A5A5; smp_right = 24'h5A5A5A;
    run_slave(2'd3, 2'd3, 32, 3, 24'hA5A5A5, 24'h5A5A5A, "R5 R10 slave I2S-style");

    finish_run();
  end
endmodule